// File: doc/BRIEF.md
# Latency-Hiding Thread Context Scheduler

This block decides which hardware thread context owns one packet-processing engine in any given cycle. Every context is always in one of three states: ready, running or sleeping. When the running context starts a memory access, it goes to sleep and gives up the engine. In that same clock edge, the scheduler hands the engine to another ready context, so the engine keeps doing useful work while the memory access is outstanding.

A sleeping context returns to the ready pool only when a completion event that carries its number arrives. A running context may also step aside voluntarily without sleeping. Contexts are chosen in round-robin order. The search starts at the context numbered one above the last granted one and wraps past the highest number. When every context is asleep, the engine is idle and the valid output is low.

Top module: `ctx_arb`

## Requirements
- R1: While `rst_n` is low, `run_valid_o` is low. On the first rising edge with `rst_n` high, context 0 is granted, so `run_valid_o` is high and `run_id_o` is 0.
- R2: When the running context raises its bit of `mem_req_i`, it sleeps at the next edge. At that same edge, the next ready context is granted with no idle cycle in between.
- R3: A sleeping context is never granted until `done_valid_i` is high with `done_id_i` equal to its number. At that edge it becomes eligible, and it is granted at once if the engine is free.
- R4: When the running context raises its bit of `yield_i`, it becomes ready and the next ready context is granted. If it is the only ready context, it is granted again.
- R5: The grant search begins at the context numbered one above the last granted one, counts upward and wraps from NUM_CTX-1 to 0.
- R6: A `mem_req_i` or `yield_i` bit of a context that is not running has no effect. A completion event for a context that is not sleeping has no effect.
- R7: When no context is ready, `run_valid_o` is low. A completion event for a sleeping context during idle makes that context run from the next edge.
- R8: A memory request and a completion event for the same running context in the same cycle leave it ready, not sleeping.
- R9: When the running context raises `mem_req_i` and `yield_i` in the same cycle, the memory request wins and the context sleeps.
- R10: At most one context is running. `run_valid_o` is high exactly when one is running, and `run_id_o` gives its number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req_i | input | NUM_CTX | Bit i: context i issues a memory request |
| yield_i | input | NUM_CTX | Bit i: context i gives up the engine and stays ready |
| done_valid_i | input | 1 | A memory completion event is present |
| done_id_i | input | ID_W | Binary number of the context the completion belongs to |
| run_id_o | output | ID_W | Binary number of the running context |
| run_valid_o | output | 1 | A context is running |

## Verification
The hardest case to reach is a completion event for the running context that arrives in the same cycle as that context's memory request. The context must end up ready and not running. This outcome cannot be seen directly, so the stimulus first wakes a second context so that the second one takes the grant. A later memory request from the second context must then hand the engine back to the first context, with no completion event in between. Strobes on idle contexts are checked the same way: the affected context is first made ready, then stimulated, and then shown to be granted.

// File: rtl/ctx_arb_pkg.sv
// Package: types shared by the context scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package ctx_arb_pkg;
    typedef enum logic [1:0] {
        CTX_READY    = 2'd0,
        CTX_RUNNING  = 2'd1,
        CTX_SLEEPING = 2'd2
    } ctx_state_e;
endpackage

// File: rtl/ctx_arb_slot.sv
// Module: per-context state holder. It tracks ready/running/sleeping and
// reports whether the context will be eligible after this cycle's events.
// Assumes: the grant is given only when ready_nxt_o is high, and strobes
// act only while this context is running.
module ctx_arb_slot
    import ctx_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mem_req_i,
    input  logic yield_i,
    input  logic wake_i,
    input  logic grant_i,
    output logic ready_nxt_o,
    output logic running_o
);
    ctx_state_e state_q;
    ctx_state_e after_ev;

    // Apply the release and wake events before any grant is considered.
    always_comb begin
        after_ev = state_q;
        unique case (state_q)
            CTX_RUNNING: begin
                if (mem_req_i)    after_ev = wake_i ? CTX_READY : CTX_SLEEPING;
                else if (yield_i) after_ev = CTX_READY;
            end
            CTX_SLEEPING: begin
                if (wake_i) after_ev = CTX_READY;
            end
            default: after_ev = state_q;
        endcase
    end

    assign ready_nxt_o = (after_ev == CTX_READY);
    assign running_o   = (state_q == CTX_RUNNING);

    // State register; a grant turns the context into the running one.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= CTX_READY;
        else if (grant_i) state_q <= CTX_RUNNING;
        else              state_q <= after_ev;
    end
endmodule

// File: rtl/ctx_arb_rr.sv
// Module: combinational round-robin picker. It searches upward from
// last_i + 1, wrapping at N-1, for the first set request bit.
// Assumes: N >= 1; W is wide enough to hold N-1.
module ctx_arb_rr #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] req_i,
    input  logic [W-1:0] last_i,
    output logic         any_o,
    output logic [W-1:0] id_o
);
    // Walk the offsets in order and keep the first hit.
    always_comb begin
        any_o = 1'b0;
        id_o  = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_i) + k) % N;
            if (!any_o && req_i[idx]) begin
                any_o = 1'b1;
                id_o  = W'(idx);
            end
        end
    end
endmodule

// File: rtl/ctx_arb.sv
// Module: thread context scheduler for one engine. A memory request puts
// the running context to sleep, a tagged completion wakes it, and a free
// engine is handed to the next ready context in round-robin order.
// Assumes: at most one completion event per cycle; synchronous active-low
// reset; outputs are registered.
module ctx_arb #(
    parameter  int NUM_CTX = 8,
    localparam int ID_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTX-1:0] mem_req_i,
    input  logic [NUM_CTX-1:0] yield_i,
    input  logic               done_valid_i,
    input  logic [ID_W-1:0]    done_id_i,
    output logic [ID_W-1:0]    run_id_o,
    output logic               run_valid_o
);
    logic [NUM_CTX-1:0] wake_vec;
    logic [NUM_CTX-1:0] ready_nxt_vec;
    logic [NUM_CTX-1:0] running_vec;
    logic [NUM_CTX-1:0] grant_vec;
    logic               releasing;
    logic               engine_free;
    logic               pick_any;
    logic [ID_W-1:0]    pick_id;
    logic               run_valid_q;
    logic [ID_W-1:0]    run_id_q;
    logic [ID_W-1:0]    last_q;

    // Decode the completion tag into a one-hot wake vector.
    always_comb begin
        wake_vec = '0;
        if (done_valid_i) wake_vec[done_id_i] = 1'b1;
    end

    generate
        for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
            ctx_arb_slot u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .mem_req_i   (mem_req_i[i]),
                .yield_i     (yield_i[i]),
                .wake_i      (wake_vec[i]),
                .grant_i     (grant_vec[i]),
                .ready_nxt_o (ready_nxt_vec[i]),
                .running_o   (running_vec[i])
            );
        end
    endgenerate

    ctx_arb_rr #(.N(NUM_CTX), .W(ID_W)) u_rr (
        .req_i  (ready_nxt_vec),
        .last_i (last_q),
        .any_o  (pick_any),
        .id_o   (pick_id)
    );

    // The engine is free when nobody runs or the runner lets go this cycle.
    assign releasing   = |(running_vec & (mem_req_i | yield_i));
    assign engine_free = !run_valid_q || releasing;

    // Issue a one-hot grant only when the engine is free.
    always_comb begin
        grant_vec = '0;
        if (engine_free && pick_any) grant_vec[pick_id] = 1'b1;
    end

    // Running-context registers and the round-robin history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_valid_q <= 1'b0;
            run_id_q    <= '0;
            last_q      <= ID_W'(NUM_CTX - 1);
        end else if (engine_free) begin
            run_valid_q <= pick_any;
            if (pick_any) begin
                run_id_q <= pick_id;
                last_q   <= pick_id;
            end
        end
    end

    assign run_id_o    = run_id_q;
    assign run_valid_o = run_valid_q;
endmodule

// File: rtl/ctx_arb_chk.sv
// Module: assertion checker for ctx_arb, attached with bind below.
// Assumes: it sees the top ports and the per-context running vector.
module ctx_arb_chk #(
    parameter  int NUM_CTX = 8,
    localparam int ID_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CTX-1:0] mem_req_i,
    input logic [NUM_CTX-1:0] yield_i,
    input logic               done_valid_i,
    input logic [ID_W-1:0]    done_id_i,
    input logic [ID_W-1:0]    run_id_o,
    input logic               run_valid_o,
    input logic [NUM_CTX-1:0] running_vec
);
    logic seen_run;

    // Remember that some context has run since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           seen_run <= 1'b0;
        else if (run_valid_o) seen_run <= 1'b1;
    end

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !run_valid_o);

    a_r1_first_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> (run_valid_o && run_id_o == '0));

    a_r2_sleep_swaps: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid_o && mem_req_i[run_id_o] &&
         !(done_valid_i && done_id_i == run_id_o))
        |=> (!run_valid_o || run_id_o != $past(run_id_o)));

    a_r4_holds_engine: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid_o && !mem_req_i[run_id_o] && !yield_i[run_id_o])
        |=> (run_valid_o && run_id_o == $past(run_id_o)));

    a_r7_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_run && !run_valid_o && done_valid_i)
        |=> (run_valid_o && run_id_o == $past(done_id_i)));

    a_r10_one_runner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(running_vec));

    a_r10_valid_matches: assert property (@(posedge clk) disable iff (!rst_n)
        ((|running_vec) == run_valid_o) &&
        (!run_valid_o || running_vec[run_id_o]));
endmodule

bind ctx_arb ctx_arb_chk #(.NUM_CTX(NUM_CTX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req_i    (mem_req_i),
    .yield_i      (yield_i),
    .done_valid_i (done_valid_i),
    .done_id_i    (done_id_i),
    .run_id_o     (run_id_o),
    .run_valid_o  (run_valid_o),
    .running_vec  (running_vec)
);

// File: tb/ctx_arb_bench.sv
// Directed bench for ctx_arb with eight contexts.
module ctx_arb_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mreq = '0;
    logic [7:0] yld = '0;
    logic       dv = 1'b0;
    logic [2:0] did = '0;
    logic [2:0] run_id;
    logic       run_valid;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         finished = 0;

    ctx_arb #(.NUM_CTX(8)) u_ctx_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_req_i    (mreq),
        .yield_i      (yld),
        .done_valid_i (dv),
        .done_id_i    (did),
        .run_id_o     (run_id),
        .run_valid_o  (run_valid)
    );

    always #10 clk = ~clk;

    // Present one cycle of stimulus, take the edge, then clear it.
    task automatic cyc(input logic [7:0] m, input logic [7:0] y,
                       input logic v, input logic [2:0] d);
        mreq = m; yld = y; dv = v; did = d;
        @(posedge clk); #2;
        mreq = '0; yld = '0; dv = 1'b0; did = '0;
    endtask

    task automatic chk(input string tag, input logic ev, input logic [2:0] eid);
        n_cmp++;
        if (run_valid !== ev || (ev && run_id !== eid)) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
                     tag, run_valid, run_id, ev, eid);
        end
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 idle in reset", 1'b0, 3'd0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 context 0 first", 1'b1, 3'd0);
    endtask

    task automatic t_rr_sleep;
        for (int k = 0; k < 7; k++) begin
            cyc(8'(1 << k), 8'h00, 1'b0, 3'd0);
            chk("R2 R5 sleep hands to next", 1'b1, 3'(k + 1));
        end
        cyc(8'h80, 8'h00, 1'b0, 3'd0);
        chk("R7 all asleep idle", 1'b0, 3'd0);
        cyc(8'h00, 8'h00, 1'b0, 3'd0);
        chk("R3 no wake stays idle", 1'b0, 3'd0);
    endtask

    task automatic t_wake_idle;
        cyc(8'h00, 8'h00, 1'b1, 3'd5);
        chk("R7 wake during idle", 1'b1, 3'd5);
        cyc(8'h00, 8'h00, 1'b1, 3'd2);
        chk("R3 wake does not preempt", 1'b1, 3'd5);
        cyc(8'h20, 8'h00, 1'b0, 3'd0);
        chk("R5 search wraps to 2", 1'b1, 3'd2);
    endtask

    task automatic t_ignore;
        cyc(8'h00, 8'h00, 1'b1, 3'd4);
        chk("R3 wake 4 while 2 runs", 1'b1, 3'd2);
        cyc(8'h10, 8'h10, 1'b0, 3'd0);
        chk("R6 strobes of idle ctx ignored", 1'b1, 3'd2);
        cyc(8'h00, 8'h00, 1'b1, 3'd2);
        chk("R6 completion for runner ignored", 1'b1, 3'd2);
        cyc(8'h04, 8'h00, 1'b0, 3'd0);
        chk("R6 ctx 4 still ready", 1'b1, 3'd4);
    endtask

    task automatic t_same_cycle;
        cyc(8'h00, 8'h00, 1'b1, 3'd6);
        chk("R3 wake 6 while 4 runs", 1'b1, 3'd4);
        cyc(8'h10, 8'h00, 1'b1, 3'd4);
        chk("R8 request plus completion", 1'b1, 3'd6);
        cyc(8'h40, 8'h00, 1'b0, 3'd0);
        chk("R8 ctx 4 was left ready", 1'b1, 3'd4);
        cyc(8'h10, 8'h00, 1'b0, 3'd0);
        chk("R2 R10 last one sleeps", 1'b0, 3'd0);
    endtask

    task automatic t_mem_over_yield;
        cyc(8'h00, 8'h00, 1'b1, 3'd1);
        chk("R7 wake 1", 1'b1, 3'd1);
        cyc(8'h00, 8'h00, 1'b1, 3'd3);
        chk("R3 wake 3 while 1 runs", 1'b1, 3'd1);
        cyc(8'h02, 8'h02, 1'b0, 3'd0);
        chk("R9 request beats yield", 1'b1, 3'd3);
        cyc(8'h08, 8'h00, 1'b0, 3'd0);
        chk("R9 ctx 1 slept", 1'b0, 3'd0);
    endtask

    task automatic t_yield;
        cyc(8'h00, 8'h00, 1'b1, 3'd0);
        chk("R7 wake 0", 1'b1, 3'd0);
        cyc(8'h00, 8'h01, 1'b0, 3'd0);
        chk("R4 lone yield regrants", 1'b1, 3'd0);
        cyc(8'h00, 8'h00, 1'b1, 3'd7);
        chk("R3 wake 7", 1'b1, 3'd0);
        cyc(8'h00, 8'h01, 1'b0, 3'd0);
        chk("R4 yield to 7", 1'b1, 3'd7);
        cyc(8'h00, 8'h80, 1'b0, 3'd0);
        chk("R4 R5 yield wraps to 0", 1'b1, 3'd0);
        cyc(8'h01, 8'h00, 1'b0, 3'd0);
        chk("R2 sleep hands to 7", 1'b1, 3'd7);
    endtask

    initial begin
        t_reset();
        t_rr_sleep();
        t_wake_idle();
        t_ignore();
        t_same_cycle();
        t_mem_over_yield();
        t_yield();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #200000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule